// File: doc/BRIEF.md
# Pipelined Memory Read Master

This block is a memory-mapped bus master that copies a run of 32-bit words from memory into a small local FIFO. Local logic on the user side then drains that FIFO one word at a time. A transfer is set up with a start address, a length in bytes and a flag that selects one of two address modes: step by one word per read, or repeat a single address (for example a memory-mapped queue). The transfer starts on a one-cycle start pulse.

The master keeps several reads in flight at once, so a slave with a long read latency still sees one request per cycle. It never lets the reads in flight exceed the free space in the FIFO, so returning data always has somewhere to go, even when the user side stops popping. Two completion flags report progress. One rises when the bus has accepted every request. The other rises only when the last word has landed in the FIFO, and only that second flag allows a new transfer.

Top module: `pipe_read_master`

## Requirements
- R1: After a synchronous reset, `xfer_done` and `issue_done` are high, `bus_read` is low and `user_valid` is low.
- R2: A start pulse is acted on only when `xfer_done` is high and the length holds at least one whole word (length divided by 4, rounded down, is non-zero). A pulse while a transfer is running, or with a length below 4, changes nothing. An accepted start drops `xfer_done` in the next cycle.
- R3: The first request goes to the start address. With `xfer_fixed` low, each accepted request is followed by one at an address 4 higher. With `xfer_fixed` high, every request uses the start address. While `bus_read` is high and `bus_wait` is high, `bus_read` and `bus_addr` hold their values into the next cycle.
- R4: A request is accepted in any cycle with `bus_read` high and `bus_wait` low. More than one request may be outstanding. A new request is raised only while the free FIFO space exceeds the reads still outstanding, so outstanding reads plus stored words never exceed `FIFO_DEPTH`.
- R5: Words leave the FIFO in the order they were read. Each returned word is stored unchanged, so the byte at address N appears at bits [8*(N mod 4)+7 : 8*(N mod 4)] of its word.
- R6: `user_valid` is high exactly while the FIFO holds one or more words. A cycle with `user_pop` high and `user_valid` high removes one word and shows the next one on `user_word`. A pop while the FIFO is empty has no effect.
- R7: `issue_done` rises in the cycle after the last of the length/4 requests is accepted, and stays low while requests remain.
- R8: `xfer_done` rises only after the last returned word has been written into the FIFO, and `xfer_done` high implies `issue_done` high.
- R9: A transfer issues exactly length/4 read requests (length divided by 4, rounded down).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_addr | input | ADDR_W | Start byte address, 4-byte aligned |
| xfer_bytes | input | LEN_W | Transfer length in bytes |
| xfer_fixed | input | 1 | 1: every read uses the start address |
| xfer_start | input | 1 | One-cycle start pulse |
| issue_done | output | 1 | High when no requests remain to be issued |
| xfer_done | output | 1 | High when idle with all data in the FIFO |
| user_word | output | 32 | Word at the FIFO head |
| user_valid | output | 1 | FIFO holds at least one word |
| user_pop | input | 1 | Removes the head word |
| bus_addr | output | ADDR_W | Read address |
| bus_read | output | 1 | Read request |
| bus_wait | input | 1 | Slave stalls the current request |
| bus_rdata | input | 32 | Returned read data |
| bus_rvalid | input | 1 | `bus_rdata` carries a returned word |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 4 and the default 32-bit address and length widths. It pairs the block with a slave model that has a fixed three-cycle read latency. With a FIFO that shallow, the space limit cuts in on every transfer longer than four words. A transfer with no pops stalls after exactly four requests, so that throttling and the refused start pulse can be seen at the ports. The three-cycle latency keeps several reads outstanding, and a periodic wait pattern exercises the hold-under-stall rule.

// File: rtl/rdm_pkg.sv
// Shared constants and types for the pipelined read master.
// Assumes a 32-bit data path made of four byte lanes.
package rdm_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_SHIFT = 2;
    typedef logic [8*WORD_BYTES-1:0] word_t;
endpackage

// File: rtl/rdm_fifo.sv
// Synchronous word FIFO holding returned read data.
// Assumes the writer never pushes while full; the issue side guarantees this.
// A pop while empty is discarded. The head word is shown without a register stage.
module rdm_fifo
    import rdm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  word_t            push_data,
    input  logic             pop,
    output word_t            head,
    output logic [CNT_W-1:0] fill
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] fill_q;
    logic             do_pop;

    assign do_pop = pop && (fill_q != '0);

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    // Storage write on each pushed word.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (push)   wr_ptr <= wr_nxt;
            if (do_pop) rd_ptr <= rd_nxt;
            if (push && !do_pop)      fill_q <= fill_q + CNT_W'(1);
            else if (!push && do_pop) fill_q <= fill_q - CNT_W'(1);
        end
    end

    assign head = mem[rd_ptr];
    assign fill = fill_q;
endmodule

// File: rtl/rdm_issue.sv
// Request generator: holds the current address and the count of reads still to issue.
// Assumes start is only pulsed while idle. The request is raised only when room is
// granted, and room cannot fall while a request waits, so the request stays stable.
module rdm_issue
    import rdm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len_bytes,
    input  logic              fixed,
    input  logic              room,
    input  logic              accept,
    output logic [ADDR_W-1:0] addr,
    output logic              read_req,
    output logic              all_issued
);
    localparam int WL_W = LEN_W - WORD_SHIFT;

    logic [WL_W-1:0]   left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fixed_q;
    logic              unused_len_lsb;

    assign unused_len_lsb = ^len_bytes[WORD_SHIFT-1:0];

    // Load a new run on start, then step on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            addr_q  <= '0;
            fixed_q <= 1'b0;
        end else if (start) begin
            left_q  <= len_bytes[LEN_W-1:WORD_SHIFT];
            addr_q  <= base;
            fixed_q <= fixed;
        end else if (accept) begin
            left_q <= left_q - WL_W'(1);
            if (!fixed_q) addr_q <= addr_q + ADDR_W'(WORD_BYTES);
        end
    end

    assign all_issued = (left_q == '0);
    assign read_req   = !all_issued && room;
    assign addr       = addr_q;
endmodule

// File: rtl/rdm_track.sv
// Counts reads accepted by the bus whose data has not yet returned.
// Assumes the slave returns exactly one word per accepted read.
module rdm_track #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issued,
    input  logic             returned,
    output logic [CNT_W-1:0] pend
);
    logic [CNT_W-1:0] pend_q;

    // Up on issue, down on return, unchanged when both or neither occur.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({issued, returned})
                2'b10:   pend_q <= pend_q + CNT_W'(1);
                2'b01:   pend_q <= pend_q - CNT_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/pipe_read_master.sv
// Pipelined memory read master top level.
// Issues length/4 single-word reads, keeps several in flight, and stores returned
// words in a local FIFO. Admission rule: free FIFO space must exceed the reads
// outstanding. Assumes aligned start addresses and a slave with in-order returns.
module pipe_read_master
    import rdm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [LEN_W-1:0]  xfer_bytes,
    input  logic              xfer_fixed,
    input  logic              xfer_start,
    output logic              issue_done,
    output logic              xfer_done,
    output logic [31:0]       user_word,
    output logic              user_valid,
    input  logic              user_pop,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    input  logic              bus_wait,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rvalid
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [CNT_W-1:0] fifo_fill;
    logic [CNT_W-1:0] pend_cnt;
    logic [CNT_W-1:0] free_cnt;
    logic             room;
    logic             accept;
    logic             start_ok;
    logic             all_issued;
    logic             read_req;

    assign free_cnt = CNT_W'(FIFO_DEPTH) - fifo_fill;
    assign room     = free_cnt > pend_cnt;
    assign accept   = read_req && !bus_wait;
    assign start_ok = xfer_start && xfer_done
                      && (xfer_bytes[LEN_W-1:WORD_SHIFT] != '0);

    rdm_issue #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_ok),
        .base       (xfer_addr),
        .len_bytes  (xfer_bytes),
        .fixed      (xfer_fixed),
        .room       (room),
        .accept     (accept),
        .addr       (bus_addr),
        .read_req   (read_req),
        .all_issued (all_issued)
    );

    rdm_track #(
        .CNT_W (CNT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .issued   (accept),
        .returned (bus_rvalid),
        .pend     (pend_cnt)
    );

    rdm_fifo #(
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (bus_rvalid),
        .push_data (bus_rdata),
        .pop       (user_pop),
        .head      (user_word),
        .fill      (fifo_fill)
    );

    assign bus_read   = read_req;
    assign issue_done = all_issued;
    assign xfer_done  = all_issued && (pend_cnt == '0);
    assign user_valid = (fifo_fill != '0);
endmodule

// File: rtl/rdm_checker.sv
// Property checker for the pipelined read master, attached by bind.
// Observes the bus, the completion flags and the FIFO and in-flight counters.
module rdm_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_read,
    input logic              bus_wait,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              issue_done,
    input logic              xfer_done,
    input logic              user_valid,
    input logic [CNT_W-1:0]  fill,
    input logic [CNT_W-1:0]  pend
);
    // R3: a stalled request is held unchanged.
    assert_hold_on_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && bus_wait) |=> (bus_read && $stable(bus_addr)));

    // R4: stored words plus reads in flight never exceed the FIFO depth.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pend) + int'(fill)) <= DEPTH);

    // R4: returning data never meets a full FIFO.
    assert_push_has_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (int'(fill) < DEPTH));

    // R6: an empty FIFO gains a word only through returned data, never through a pop.
    assert_empty_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !user_valid |=> (user_valid == $past(bus_rvalid)));

    // R7: no request is raised once all requests have been issued.
    assert_quiet_when_issued_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_done |-> !bus_read);

    // R8: full completion implies issue completion.
    assert_done_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> issue_done);
endmodule

bind pipe_read_master rdm_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DEPTH  (FIFO_DEPTH)
) u_rdm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_read   (bus_read),
    .bus_wait   (bus_wait),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .issue_done (issue_done),
    .xfer_done  (xfer_done),
    .user_valid (user_valid),
    .fill       (fifo_fill),
    .pend       (pend_cnt)
);

// File: tb/test_pipe_read_master.sv
`timescale 1ns/1ps
// Bench for the pipelined read master: a vector table of transfers walked by one
// loop, then directed checks. Memory model: byte at address N holds N[7:0].
module test_pipe_read_master;
    localparam int DEPTH = 4;
    localparam int LAT   = 3;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] len;
        logic        fixed;
        logic        stall;
        logic        slow;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{base: 32'h0000_0000, len: 16'd8,  fixed: 1'b0, stall: 1'b0, slow: 1'b0},
        '{base: 32'h0000_0100, len: 16'd64, fixed: 1'b0, stall: 1'b0, slow: 1'b0},
        '{base: 32'h0000_0040, len: 16'd24, fixed: 1'b1, stall: 1'b0, slow: 1'b0},
        '{base: 32'h0000_0200, len: 16'd36, fixed: 1'b0, stall: 1'b1, slow: 1'b1},
        '{base: 32'h0000_0FFC, len: 16'd14, fixed: 1'b0, stall: 1'b1, slow: 1'b0},
        '{base: 32'h0000_0010, len: 16'd4,  fixed: 1'b0, stall: 1'b0, slow: 1'b1},
        '{base: 32'h0000_0080, len: 16'd20, fixed: 1'b1, stall: 1'b1, slow: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] xfer_addr;
    logic [31:0] xfer_bytes;
    logic        xfer_fixed;
    logic        xfer_start;
    logic        issue_done, xfer_done;
    logic [31:0] user_word;
    logic        user_valid;
    logic        user_pop;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        bus_wait;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int acc_x = 0, ret_x = 0, got = 0, n_words = 0, max_fl = 0;
    logic [31:0] cur_base = '0;
    logic        cur_fixed = 1'b0;
    logic        stall_mode = 1'b0;

    logic [LAT-1:0] sv_v;
    logic [31:0]    sv_a [LAT];
    int             wait_cnt;

    always #5 clk = ~clk;

    pipe_read_master #(
        .ADDR_W     (32),
        .LEN_W      (32),
        .FIFO_DEPTH (DEPTH)
    ) i_pipe_read_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_addr  (xfer_addr),
        .xfer_bytes (xfer_bytes),
        .xfer_fixed (xfer_fixed),
        .xfer_start (xfer_start),
        .issue_done (issue_done),
        .xfer_done  (xfer_done),
        .user_word  (user_word),
        .user_valid (user_valid),
        .user_pop   (user_pop),
        .bus_addr   (bus_addr),
        .bus_read   (bus_read),
        .bus_wait   (bus_wait),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [7:0] b;
        b = a[7:0];
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    function automatic logic [31:0] exp_word(input int i);
        return word_at(cur_fixed ? cur_base : cur_base + 32'(4 * i));
    endfunction

    // Slave model: fixed read latency, optional periodic wait pattern.
    always @(posedge clk) begin
        if (!rst_n) begin
            sv_v     <= '0;
            wait_cnt <= 0;
            bus_wait <= 1'b0;
        end else begin
            sv_v    <= {sv_v[LAT-2:0], bus_read && !bus_wait};
            sv_a[0] <= bus_addr;
            for (int k = 1; k < LAT; k++) sv_a[k] <= sv_a[k-1];
            wait_cnt <= (wait_cnt == 2) ? 0 : wait_cnt + 1;
            bus_wait <= stall_mode && (wait_cnt == 0);
        end
    end
    assign bus_rvalid = sv_v[LAT-1];
    assign bus_rdata  = word_at(sv_a[LAT-1]);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // One cycle: observe accepted requests and returns just before the coming edge.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (rst_n && bus_read && !bus_wait) begin
            check("R3 request address", bus_addr,
                  cur_fixed ? cur_base : cur_base + 32'(4 * acc_x));
            acc_x++;
        end
        if (rst_n && bus_rvalid) ret_x++;
        if (acc_x - ret_x > max_fl) max_fl = acc_x - ret_x;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual cycle %0d expected below 100000", cyc);
            finish_run();
        end
    endtask

    task automatic start_xfer(input logic [31:0] base, input logic [31:0] len,
                              input logic fixed, input logic stall);
        while (!xfer_done) tick();
        stall_mode = stall;
        cur_base   = base;
        cur_fixed  = fixed;
        acc_x = 0; ret_x = 0; got = 0;
        n_words    = int'(len / 4);
        xfer_addr  = base;
        xfer_bytes = len;
        xfer_fixed = fixed;
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        check("R2 done drops after accepted start", {31'd0, xfer_done}, 32'd0);
    endtask

    task automatic drain(input logic slow);
        logic early_seen, done_seen;
        early_seen = 1'b0;
        done_seen  = 1'b0;
        while (!(got == n_words && xfer_done)) begin
            if (issue_done && !early_seen) begin
                early_seen = 1'b1;
                check("R7 requests accepted at issue-done", 32'(acc_x), 32'(n_words));
            end
            if (xfer_done && !done_seen) begin
                done_seen = 1'b1;
                check("R8 words returned at done", 32'(ret_x), 32'(n_words));
            end
            if (user_valid && (!slow || cyc[1])) begin
                check("R5 FIFO word order and byte lanes", user_word, exp_word(got));
                got++;
                user_pop = 1'b1;
            end else begin
                user_pop = 1'b0;
            end
            tick();
        end
        user_pop = 1'b0;
        check("R8 words returned at done", 32'(ret_x), 32'(n_words));
        check("R7 issue-done high at end", {31'd0, issue_done}, 32'd1);
        check("R9 request count", 32'(acc_x), 32'(n_words));
        check("R6 FIFO empty after drain", {31'd0, user_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        xfer_addr = '0; xfer_bytes = '0; xfer_fixed = 1'b0; xfer_start = 1'b0;
        user_pop = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 done after reset", {31'd0, xfer_done}, 32'd1);
        check("R1 issue-done after reset", {31'd0, issue_done}, 32'd1);
        check("R1 read low after reset", {31'd0, bus_read}, 32'd0);
        check("R1 FIFO empty after reset", {31'd0, user_valid}, 32'd0);

        // R6: pops on an empty FIFO change nothing
        user_pop = 1'b1;
        repeat (3) tick();
        user_pop = 1'b0;
        tick();
        check("R6 pop on empty keeps FIFO empty", {31'd0, user_valid}, 32'd0);

        // R2: a start with less than one word is ignored
        acc_x = 0;
        xfer_addr = 32'h40; xfer_bytes = 32'd3; xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        check("R2 short length start ignored", {31'd0, xfer_done}, 32'd1);
        repeat (5) tick();
        check("R2 no requests after short length", 32'(acc_x), 32'd0);

        // Vector table
        for (int v = 0; v < 7; v++) begin
            start_xfer(VECS[v].base, 32'(VECS[v].len), VECS[v].fixed, VECS[v].stall);
            drain(VECS[v].slow);
        end
        check("R4 several reads outstanding", 32'(max_fl >= 2), 32'd1);
        check("R4 outstanding within depth", 32'(max_fl <= DEPTH), 32'd1);

        // R4: no pops, so issue stops when the FIFO space is committed
        start_xfer(32'h300, 32'd40, 1'b0, 1'b0);
        user_pop = 1'b0;
        repeat (30) tick();
        check("R4 issue throttled by FIFO space", 32'(acc_x), 32'(DEPTH));
        check("R7 issue-done low while requests remain", {31'd0, issue_done}, 32'd0);
        check("R8 done low while requests remain", {31'd0, xfer_done}, 32'd0);
        check("R6 valid with stored words", {31'd0, user_valid}, 32'd1);
        check("R5 head is first word", user_word, word_at(32'h300));

        // R2: a start while busy is ignored
        xfer_addr = 32'h500; xfer_bytes = 32'd8; xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        repeat (3) tick();
        check("R2 start while busy ignored", 32'(acc_x), 32'(DEPTH));
        drain(1'b0);

        finish_run();
    end
endmodule